// File: doc/BRIEF.md
# Sticky Error Status Register

This block holds the error status of a byte-oriented serial bus controller. The protocol engine gives it single-cycle event pulses and one level signal. It keeps each condition as a sticky flag until that flag's own clear rule lets it go. A processor reads the flags through a read strobe, and a one-bit summary output can serve as an interrupt request.

The five flags are receive overflow, transmit abort, break, CRC failure and invalid frame. The overflow flag comes from an occupancy tracker for the receive holding register. The tracker records when a byte is loaded and when it is read out. A read of the status register returns the flags as they stood in the strobe cycle. The same read clears the flags that may be cleared by a read. An event that lands in the cycle of the read survives that read. Two control inputs, an enable and a disable, hold every flag at zero while the block is not active.

Top module: `err_status`

## Requirements
- R1: The status word places receive overflow at bit 5, transmit abort at bit 4, break at bit 3, CRC failure at bit 2 and invalid frame at bit 1. Bits 7, 6 and 0 always read 0.
- R2: `rd_data_o` takes the flag values present in the cycle `rd_strobe_i` is high and shows them from the next cycle on. It keeps that value until the next strobe.
- R3: The overflow flag sets when `rx_load_i` arrives while the holding register is still unread. A load into an empty register does not set it. A load in the same cycle as `rx_data_rd_i` does not set it either.
- R4: The overflow, CRC and invalid-frame flags clear on a status read that captured them set.
- R5: The transmit-abort flag is not cleared by a status read.
- R6: The break flag is set in every cycle after one in which `brk_i` is high. Reads while `brk_i` is high leave it set. The first read after `brk_i` falls clears it.
- R7: An event that arrives in the same cycle as a clearing read leaves its flag set. The read still returns the earlier value.
- R8: While `enable_i` is 0 or `disable_i` is 1, all flags are held at 0, events are ignored and the holding register counts as empty.
- R9: `error_any_o` is 1 exactly when at least one flag is set.
- R10: After reset, all flags, `rd_data_o` and `error_any_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; 0 clears and holds all flags |
| disable_i | input | 1 | Block disable; 1 clears and holds all flags |
| rd_strobe_i | input | 1 | Status register read strobe |
| rd_data_o | output | REG_W | Status word captured at the last strobe |
| rx_load_i | input | 1 | Received byte moved into the holding register |
| rx_data_rd_i | input | 1 | Holding register read by software |
| tx_abort_i | input | 1 | Transmit request aborted (pulse) |
| brk_i | input | 1 | Break symbol currently present (level) |
| crc_err_i | input | 1 | CRC check failed (pulse) |
| ifd_i | input | 1 | Invalid frame detected (pulse) |
| error_any_o | output | 1 | OR of all flags |

## Verification
The hardest case to reach is the race between a clearing read and an event on the same edge. The stimulus drives a CRC pulse and the read strobe in one cycle. It then expects the old word from that read and the flag still set on the next read. The break release is reached by holding `brk_i` across two reads, then dropping it for one idle cycle before a further read. The overflow path needs a first load that fills the holding register, then a second load with no data read in between.

// File: rtl/err_status_pkg.sv
package err_status_pkg;
  localparam int REG_W_DEF = 8;
  localparam int OVF_BIT   = 5;
  localparam int TRA_BIT   = 4;
  localparam int BRK_BIT   = 3;
  localparam int CRC_BIT   = 2;
  localparam int IFD_BIT   = 1;

  function automatic bit is_flag(int b);
    return (b >= IFD_BIT) && (b <= OVF_BIT);
  endfunction

  // transmit abort survives reads; all others clear on read
  function automatic bit read_clears(int b);
    return b != TRA_BIT;
  endfunction
endpackage

// File: rtl/err_flag.sv
module err_flag #(
  parameter bit READ_CLEAR = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic set_i,
  input  logic rd_i,
  output logic flag_o
);
  logic flag_q;
  logic clr;

  generate
    if (READ_CLEAR) begin : g_rc
      assign clr = rd_i & flag_q;
    end else begin : g_hold
      assign clr = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (!active_i) flag_q <= 1'b0;
    else                flag_q <= set_i | (flag_q & ~clr);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/err_occupancy.sv
module err_occupancy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic load_i,
  input  logic drain_i,
  output logic ovf_o
);
  logic full_q;

  // same-cycle drain makes room for the new byte
  assign ovf_o = active_i & load_i & full_q & ~drain_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        full_q <= 1'b0;
    else if (!active_i) full_q <= 1'b0;
    else if (load_i)    full_q <= 1'b1;
    else if (drain_i)   full_q <= 1'b0;
  end
endmodule

// File: rtl/err_snapshot.sv
module err_snapshot #(
  parameter int REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [REG_W-1:0] flags_i,
  output logic [REG_W-1:0] data_o
);
  logic [REG_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (rd_i) data_q <= flags_i;
  end

  assign data_o = data_q;
endmodule

// File: rtl/err_status.sv
module err_status #(
  parameter int REG_W = err_status_pkg::REG_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             disable_i,
  input  logic             rd_strobe_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             rx_load_i,
  input  logic             rx_data_rd_i,
  input  logic             tx_abort_i,
  input  logic             brk_i,
  input  logic             crc_err_i,
  input  logic             ifd_i,
  output logic             error_any_o
);
  import err_status_pkg::*;

  logic             active;
  logic             ovf_evt;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] flags_q;

  assign active = enable_i & ~disable_i;

  err_occupancy u_occ (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .load_i  (rx_load_i),
    .drain_i (rx_data_rd_i),
    .ovf_o   (ovf_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[OVF_BIT] = ovf_evt;
    set_vec[TRA_BIT] = tx_abort_i;
    set_vec[BRK_BIT] = brk_i;
    set_vec[CRC_BIT] = crc_err_i;
    set_vec[IFD_BIT] = ifd_i;
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (is_flag(b)) begin : g_flag
      err_flag #(.READ_CLEAR(read_clears(b))) u_flag (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .active_i(active),
        .set_i   (set_vec[b]),
        .rd_i    (rd_strobe_i),
        .flag_o  (flags_q[b])
      );
    end else begin : g_rsvd
      assign flags_q[b] = 1'b0;
    end
  end

  err_snapshot #(.REG_W(REG_W)) u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_strobe_i),
    .flags_i(flags_q),
    .data_o (rd_data_o)
  );

  assign error_any_o = |flags_q;
endmodule

// File: rtl/err_status_chk.sv
module err_status_chk #(
  parameter int REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             active_i,
  input logic             brk_i,
  input logic             crc_err_i,
  input logic             rd_strobe_i,
  input logic [REG_W-1:0] flags_i,
  input logic [REG_W-1:0] rd_data_i
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_data_i >> 6) == '0) && !rd_data_i[0]);

  // R2
  snapshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i |=> rd_data_i == $past(flags_i));

  // R5
  tra_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && flags_i[4]) |=> flags_i[4]);

  // R6
  brk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && brk_i) |=> flags_i[3]);

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && crc_err_i) |=> flags_i[2]);

  // R8
  inactive_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> flags_i == '0);
endmodule

bind err_status err_status_chk #(.REG_W(REG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .active_i   (active),
  .brk_i      (brk_i),
  .crc_err_i  (crc_err_i),
  .rd_strobe_i(rd_strobe_i),
  .flags_i    (flags_q),
  .rd_data_i  (rd_data_o)
);

// File: tb/err_status_tb_top.sv
`timescale 1ns/1ps
module err_status_tb_top;
  localparam int REG_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, disable_i = 1'b0, rd_strobe_i = 1'b0;
  logic rx_load_i = 1'b0, rx_data_rd_i = 1'b0, tx_abort_i = 1'b0;
  logic brk_i = 1'b0, crc_err_i = 1'b0, ifd_i = 1'b0;
  logic [REG_W-1:0] rd_data_o;
  logic error_any_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #2 clk_i = ~clk_i;

  err_status #(.REG_W(REG_W)) dut_i (.*);

  function automatic void check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endfunction

  // monitor: rd_data_o is valid at the negedge after the strobe edge
  always @(posedge clk_i) rd_seen <= rd_strobe_i;
  always @(negedge clk_i) begin
    if (rd_seen && exp_q.size() > 0) check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
  end

  // drive {load, data_rd, tx_abort, crc, ifd, rd} for one cycle
  task automatic drive(input logic [5:0] v, input logic [7:0] exp = 8'h00, input string tag = "");
    {rx_load_i, rx_data_rd_i, tx_abort_i, crc_err_i, ifd_i, rd_strobe_i} = v;
    if (v[0]) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk_i);
    {rx_load_i, rx_data_rd_i, tx_abort_i, crc_err_i, ifd_i, rd_strobe_i} = '0;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    drive(6'b000001, exp, tag);
  endtask

  task automatic idle();
    @(negedge clk_i);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 rd_data", rd_data_o, 8'h00);
    check("R10 error_any", {7'b0, error_any_o}, 8'h00);
    rst_ni = 1'b1; enable_i = 1'b1;
    idle();
    rd(8'h00, "R1 idle word");
    // R3 load into empty then full
    drive(6'b100000);
    rd(8'h00, "R3 load into empty");
    drive(6'b100000);
    check("R9 any after ovf", {7'b0, error_any_o}, 8'h01);
    rd(8'h20, "R3 R1 overflow bit5");
    rd(8'h00, "R4 ovf cleared");
    drive(6'b110000);
    rd(8'h00, "R3 load with same-cycle drain");
    // R5
    drive(6'b001000);
    rd(8'h10, "R1 tra bit4");
    rd(8'h10, "R5 tra kept after read");
    // R4
    drive(6'b000110);
    rd(8'h16, "R1 crc bit2 ifd bit1");
    rd(8'h10, "R4 crc ifd cleared");
    // R7
    drive(6'b000101, 8'h10, "R7 read returns old word");
    rd(8'h14, "R7 crc kept");
    rd(8'h10, "R7 crc then cleared");
    // R6
    brk_i = 1'b1; idle();
    rd(8'h18, "R6 R1 brk bit3");
    rd(8'h18, "R6 brk kept during break");
    brk_i = 1'b0; idle();
    rd(8'h18, "R6 first read after break");
    rd(8'h10, "R6 brk cleared");
    // R8
    disable_i = 1'b1; idle();
    check("R8 any while disabled", {7'b0, error_any_o}, 8'h00);
    drive(6'b000100);
    disable_i = 1'b0; idle();
    rd(8'h00, "R8 disable cleared, event ignored");
    drive(6'b100000);
    enable_i = 1'b0; idle();
    drive(6'b001000);
    enable_i = 1'b1; idle();
    drive(6'b100000);
    rd(8'h00, "R8 occupancy cleared, tra ignored");
    check("R9 any idle", {7'b0, error_any_o}, 8'h00);
    idle(); idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule